// File: doc/BRIEF.md
# Vector Load/Store Displacement Rewriter

This block produces the replacement displacement for one element of a vectorised load or store. It takes the raw displacement field of the instruction, in either the 16-bit D layout or the 14-bit word-scaled DS layout. It works out which element is being accessed from the source or destination step counters and their subvector substeps, or from a remap index for loads. It then folds that element offset into the displacement in one of two stride styles.

In unit-stride style, consecutive elements are spaced by the access size in bytes. In element-stride style, the displacement itself is the spacing. The result is truncated to 32 bits and, for the DS layout, scaled back down before it is handed on as a field value. A separate valid flag tells the consumer whether the field must be replaced at all.

Adding the base register and performing the memory access are left to the surrounding pipeline. The arithmetic is combinational, and a parameter selects whether a one-stage output register follows it.

Top module: `ldst_imm_gen`

## Requirements
- R1: With the form input at 0 (D layout), the displacement is the 16-bit field sign-extended to 32 bits.
- R2: With the form input at 1 (DS layout), the displacement is the low 14 bits of the field with two zero bits appended, sign-extended from the resulting bit 15.
- R3: When the access kind is 1 (load) and the remap enable is low, the element offset is src_step × (subvl + 1) + src_sub, where the subvector code subvl runs from 0 to 3.
- R4: When the access kind is 1 (load) and the remap enable is high, the element offset is the remap index, and the step and substep inputs have no effect.
- R5: When the access kind is 2 (store), the element offset is dst_step × (subvl + 1) + dst_sub, and the remap enable and remap index have no effect.
- R6: When the access kind is 0 or 3 (neither load nor store), the element offset is zero.
- R7: When the stride mode is 1 (unit stride), the result is the displacement plus the element offset times the access size, taken modulo 2^32, and the valid flag is high.
- R8: When the stride mode is 2 (element stride), the result is the displacement times the element offset, taken modulo 2^32, and the valid flag is high.
- R9: When the stride mode is 0 or 3, the valid flag is low and the output displacement is zero.
- R10: When replacing in the DS layout, the 32-bit result is shifted right logically by two before it is output.
- R11: The access-size input gives the byte count 1, 2, 4 or 8, and any other value is used as 1.
- R12: With the output register enabled (the default), results appear one clock after their inputs, and a synchronous active-low reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| i_disp_fld | input | 16 | Raw displacement field of the instruction |
| i_form | input | 1 | Layout select: 0 D, 1 DS |
| i_kind | input | 2 | Access kind: 1 load, 2 store, 0/3 other |
| i_mode | input | 2 | Stride mode: 1 unit, 2 element, 0/3 none |
| i_src_step | input | STEP_W (7) | Source element step |
| i_src_sub | input | SUB_W (2) | Source subvector substep |
| i_dst_step | input | STEP_W (7) | Destination element step |
| i_dst_sub | input | SUB_W (2) | Destination subvector substep |
| i_subvl | input | SUB_W (2) | Subvector length code, elements minus one |
| i_remap_en | input | 1 | Use the remap index for loads |
| i_remap_idx | input | STEP_W+SUB_W (9) | Remapped element index |
| i_len | input | 4 | Access size in bytes |
| o_disp | output | 32 | Replacement displacement field |
| o_valid | output | 1 | Replacement is required |

## Verification
Loads are driven with every subvector code and several step/substep pairs, so that a swapped multiplier, a missing +1 on the subvector code or a dropped substep each yield a different offset. The same element position is also issued as a store with the remap controls active, and as a load with remap, which separates the source path, the destination path and the remap path. Negative D and DS displacements are applied under both stride modes, with all four legal access sizes and one illegal size. Together these separate sign extension, DS scaling, the right shift and the size decoding, while the other stride modes and the non-access kinds show that the valid flag and the zero offset behave correctly.

// File: rtl/ldst_imm_pkg.sv
// Shared encodings for the load/store displacement rewriter.
// Assumes the two-bit kind and mode fields decoded upstream.
package ldst_imm_pkg;
    typedef enum logic [1:0] {
        KIND_OTHER = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_RSVD  = 2'd3
    } ls_kind_e;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_UNIT  = 2'd1,
        MODE_ELEM  = 2'd2,
        MODE_RSVD  = 2'd3
    } stride_mode_e;

    typedef enum logic {
        FORM_D  = 1'b0,
        FORM_DS = 1'b1
    } disp_form_e;
endpackage

// File: rtl/ldst_disp_ext.sv
// Turns the raw displacement field into a signed byte displacement.
// Assumes the DS layout keeps its word count in the low FIELD_W-2 bits.
module ldst_disp_ext #(
    parameter int FIELD_W = 16,
    parameter int RES_W   = 32
) (
    input  logic [FIELD_W-1:0] fld,
    input  logic               form,
    output logic [RES_W-1:0]   disp
);
    import ldst_imm_pkg::*;

    localparam int EXT_W = RES_W - FIELD_W;

    logic [FIELD_W-1:0] scaled;

    // Pick the field layout, scaling the DS word count to bytes.
    always_comb begin
        if (disp_form_e'(form) == FORM_DS)
            scaled = {fld[FIELD_W-3:0], 2'b00};
        else
            scaled = fld;
    end

    // Sign-extend the chosen layout to the result width.
    always_comb begin
        disp = {{EXT_W{scaled[FIELD_W-1]}}, scaled};
    end
endmodule

// File: rtl/ldst_elem_offset.sv
// Computes the element position used to scale the displacement.
// Assumes substeps never exceed the subvector code; no range check here.
module ldst_elem_offset #(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2,
    parameter int OFF_W  = STEP_W + SUB_W
) (
    input  logic [1:0]        kind,
    input  logic [STEP_W-1:0] src_step,
    input  logic [SUB_W-1:0]  src_sub,
    input  logic [STEP_W-1:0] dst_step,
    input  logic [SUB_W-1:0]  dst_sub,
    input  logic [SUB_W-1:0]  subvl,
    input  logic              remap_en,
    input  logic [OFF_W-1:0]  remap_idx,
    output logic [OFF_W-1:0]  offset
);
    import ldst_imm_pkg::*;

    logic [OFF_W-1:0] group_sz;
    logic [OFF_W-1:0] src_pos;
    logic [OFF_W-1:0] dst_pos;

    // Elements per subvector group: code plus one.
    always_comb begin
        group_sz = OFF_W'(subvl) + OFF_W'(1);
    end

    // Flat positions of the source and destination elements.
    always_comb begin
        src_pos = OFF_W'(src_step) * group_sz + OFF_W'(src_sub);
        dst_pos = OFF_W'(dst_step) * group_sz + OFF_W'(dst_sub);
    end

    // Select the position by access kind; remap applies to loads only.
    always_comb begin
        case (ls_kind_e'(kind))
            KIND_LOAD:  offset = remap_en ? remap_idx : src_pos;
            KIND_STORE: offset = dst_pos;
            default:    offset = '0;
        endcase
    end
endmodule

// File: rtl/ldst_stride_calc.sv
// Folds the element offset into the displacement per stride mode.
// Assumes the size input counts bytes; illegal sizes fall back to one.
module ldst_stride_calc #(
    parameter int RES_W = 32,
    parameter int OFF_W = 9,
    parameter int LEN_W = 4
) (
    input  logic [RES_W-1:0] disp,
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       mode,
    input  logic             form,
    output logic [RES_W-1:0] result,
    output logic             hit
);
    import ldst_imm_pkg::*;

    logic [1:0]       shamt;
    logic [RES_W-1:0] off_ext;
    logic [RES_W-1:0] raw;

    // Decode the byte count into a shift; anything else acts as one byte.
    always_comb begin
        case (len)
            LEN_W'(2): shamt = 2'd1;
            LEN_W'(4): shamt = 2'd2;
            LEN_W'(8): shamt = 2'd3;
            default:   shamt = 2'd0;
        endcase
    end

    // Widen the offset for modulo-2^RES_W arithmetic.
    always_comb begin
        off_ext = RES_W'(offset);
    end

    // Apply the stride arithmetic selected by the mode.
    always_comb begin
        case (stride_mode_e'(mode))
            MODE_UNIT: begin
                raw = disp + (off_ext << shamt);
                hit = 1'b1;
            end
            MODE_ELEM: begin
                raw = disp * off_ext;
                hit = 1'b1;
            end
            default: begin
                raw = '0;
                hit = 1'b0;
            end
        endcase
    end

    // Convert back to a DS field value when needed.
    always_comb begin
        if (disp_form_e'(form) == FORM_DS)
            result = raw >> 2;
        else
            result = raw;
    end
endmodule

// File: rtl/ldst_imm_gen.sv
// Top of the load/store displacement rewriter: offset, extension,
// stride arithmetic, then an optional output register (OUT_REG).
// Assumes inputs are stable for the cycle they are sampled in.
module ldst_imm_gen #(
    parameter int  FIELD_W = 16,
    parameter int  RES_W   = 32,
    parameter int  STEP_W  = 7,
    parameter int  SUB_W   = 2,
    parameter int  LEN_W   = 4,
    parameter bit  OUT_REG = 1'b1,
    localparam int OFF_W   = STEP_W + SUB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] i_disp_fld,
    input  logic               i_form,
    input  logic [1:0]         i_kind,
    input  logic [1:0]         i_mode,
    input  logic [STEP_W-1:0]  i_src_step,
    input  logic [SUB_W-1:0]   i_src_sub,
    input  logic [STEP_W-1:0]  i_dst_step,
    input  logic [SUB_W-1:0]   i_dst_sub,
    input  logic [SUB_W-1:0]   i_subvl,
    input  logic               i_remap_en,
    input  logic [OFF_W-1:0]   i_remap_idx,
    input  logic [LEN_W-1:0]   i_len,
    output logic [RES_W-1:0]   o_disp,
    output logic               o_valid
);
    logic [OFF_W-1:0] elem_off;
    logic [RES_W-1:0] disp_ext;
    logic [RES_W-1:0] calc_val;
    logic             calc_hit;

    ldst_elem_offset #(
        .STEP_W(STEP_W), .SUB_W(SUB_W), .OFF_W(OFF_W)
    ) u_offset (
        .kind(i_kind), .src_step(i_src_step), .src_sub(i_src_sub),
        .dst_step(i_dst_step), .dst_sub(i_dst_sub), .subvl(i_subvl),
        .remap_en(i_remap_en), .remap_idx(i_remap_idx), .offset(elem_off)
    );

    ldst_disp_ext #(
        .FIELD_W(FIELD_W), .RES_W(RES_W)
    ) u_ext (
        .fld(i_disp_fld), .form(i_form), .disp(disp_ext)
    );

    ldst_stride_calc #(
        .RES_W(RES_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
    ) u_calc (
        .disp(disp_ext), .offset(elem_off), .len(i_len), .mode(i_mode),
        .form(i_form), .result(calc_val), .hit(calc_hit)
    );

    generate
        if (OUT_REG) begin : g_reg
            // Register the result; reset clears both outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    o_disp  <= '0;
                    o_valid <= 1'b0;
                end else begin
                    o_disp  <= calc_val;
                    o_valid <= calc_hit;
                end
            end
        end else begin : g_comb
            // Drive the outputs straight from the arithmetic.
            always_comb begin
                o_disp  = calc_val;
                o_valid = calc_hit;
            end
        end
    endgenerate
endmodule

// File: rtl/ldst_imm_gen_chk.sv
// Property checker for ldst_imm_gen, attached by bind below.
// Re-times the control inputs to line up with the outputs.
module ldst_imm_gen_chk #(
    parameter int FIELD_W = 16,
    parameter int RES_W   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FIELD_W-1:0] i_disp_fld,
    input logic               i_form,
    input logic [1:0]         i_kind,
    input logic [1:0]         i_mode,
    input logic [RES_W-1:0]   o_disp,
    input logic               o_valid
);
    logic       c_live;
    logic       c_form;
    logic [1:0] c_kind;
    logic [1:0] c_mode;
    logic       c_neg;

    generate
        if (OUT_REG) begin : g_reg
            // Hold the controls that produced the current outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    c_live <= 1'b0;
                    c_form <= 1'b0;
                    c_kind <= 2'd0;
                    c_mode <= 2'd0;
                    c_neg  <= 1'b0;
                end else begin
                    c_live <= 1'b1;
                    c_form <= i_form;
                    c_kind <= i_kind;
                    c_mode <= i_mode;
                    c_neg  <= i_disp_fld[FIELD_W-1];
                end
            end

            a_reset_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (!o_valid && o_disp == '0));
        end else begin : g_comb
            // Outputs follow the current controls directly.
            always_comb begin
                c_live = 1'b1;
                c_form = i_form;
                c_kind = i_kind;
                c_mode = i_mode;
                c_neg  = i_disp_fld[FIELD_W-1];
            end
        end
    endgenerate

    a_valid_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        c_live |-> (o_valid == (c_mode == 2'd1 || c_mode == 2'd2)));

    a_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_live && !o_valid) |-> (o_disp == '0));

    a_ds_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_live && o_valid && c_form) |-> (o_disp[RES_W-1:RES_W-2] == 2'b00));

    a_no_access_elem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_live && c_mode == 2'd2 && (c_kind == 2'd0 || c_kind == 2'd3))
        |-> (o_disp == '0));

    a_d_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_live && c_mode == 2'd1 && !c_form && (c_kind == 2'd0 || c_kind == 2'd3))
        |-> (o_disp[RES_W-1] == c_neg));
endmodule

bind ldst_imm_gen ldst_imm_gen_chk #(
    .FIELD_W(FIELD_W), .RES_W(RES_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .i_disp_fld(i_disp_fld), .i_form(i_form),
    .i_kind(i_kind), .i_mode(i_mode), .o_disp(o_disp), .o_valid(o_valid)
);

// File: tb/test_ldst_imm_gen.sv
// Directed bench for ldst_imm_gen: one task per scenario.
module test_ldst_imm_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] disp_fld = '0;
    logic        form = 1'b0;
    logic [1:0]  kind = '0;
    logic [1:0]  mode = '0;
    logic [6:0]  src_step = '0;
    logic [1:0]  src_sub = '0;
    logic [6:0]  dst_step = '0;
    logic [1:0]  dst_sub = '0;
    logic [1:0]  subvl = '0;
    logic        remap_en = 1'b0;
    logic [8:0]  remap_idx = '0;
    logic [3:0]  len = 4'd1;
    logic [31:0] o_disp;
    logic        o_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_imm_gen i_ldst_imm_gen (
        .clk(clk), .rst_n(rst_n), .i_disp_fld(disp_fld), .i_form(form),
        .i_kind(kind), .i_mode(mode), .i_src_step(src_step), .i_src_sub(src_sub),
        .i_dst_step(dst_step), .i_dst_sub(dst_sub), .i_subvl(subvl),
        .i_remap_en(remap_en), .i_remap_idx(remap_idx), .i_len(len),
        .o_disp(o_disp), .o_valid(o_valid)
    );

    // Reference computed from the requirement text.
    function automatic logic [32:0] model();
        longint d, off, sz, r;
        logic [31:0] v;
        logic hit;
        d = form ? longint'($signed({disp_fld[13:0], 2'b00})) : longint'($signed(disp_fld));
        if (kind == 2'd1)
            off = remap_en ? longint'(remap_idx) : longint'(src_step) * (subvl + 1) + src_sub;
        else if (kind == 2'd2)
            off = longint'(dst_step) * (subvl + 1) + dst_sub;
        else
            off = 0;
        sz = (len == 2 || len == 4 || len == 8) ? longint'(len) : 1;
        hit = 1'b1;
        if (mode == 2'd1) r = d + off * sz;
        else if (mode == 2'd2) r = d * off;
        else begin r = 0; hit = 1'b0; end
        v = r[31:0];
        if (form && hit) v = v >> 2;
        return {hit, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] exp_d, input logic exp_v);
        checks++;
        if (o_disp !== exp_d || o_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: disp=%h valid=%b expected disp=%h valid=%b",
                     tag, o_disp, o_valid, exp_d, exp_v);
        end
    endtask

    // Drive on a falling edge, sample after the register updates.
    task automatic step_and_check(input string tag);
        logic [32:0] e;
        e = model();
        @(negedge clk);
        check(tag, e[31:0], e[32]);
    endtask

    task automatic t_reset();
        mode = 2'd1; kind = 2'd1; disp_fld = 16'h0123;
        repeat (3) @(negedge clk);
        check("R12 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 latency", 32'h0000_0123, 1'b1);
    endtask

    task automatic t_load_unit_d();
        form = 1'b0; kind = 2'd1; mode = 2'd1; disp_fld = 16'hFFF0;
        src_step = 7'd3; subvl = 2'd1; src_sub = 2'd1; len = 4'd4;
        @(negedge clk);
        check("R3 R7 R1 load unit", 32'h0000_000C, 1'b1);
        for (int s = 0; s < 4; s++) begin
            subvl = s[1:0]; src_step = 7'(5 + s); src_sub = s[1:0];
            step_and_check("R3 subvl sweep");
        end
    endtask

    task automatic t_load_remap();
        kind = 2'd1; mode = 2'd1; form = 1'b0; disp_fld = 16'h0010; len = 4'd2;
        remap_en = 1'b1; remap_idx = 9'd100; src_step = 7'd9; src_sub = 2'd3;
        @(negedge clk);
        check("R4 remap load", 32'h0000_00D8, 1'b1);
        src_step = 7'd60;
        @(negedge clk);
        check("R4 step ignored", 32'h0000_00D8, 1'b1);
        remap_en = 1'b0;
    endtask

    task automatic t_store_ds_elem();
        kind = 2'd2; mode = 2'd2; form = 1'b1; disp_fld = 16'h3FFF;
        dst_step = 7'd2; dst_sub = 2'd0; subvl = 2'd0;
        remap_en = 1'b1; remap_idx = 9'd77;
        @(negedge clk);
        check("R5 R2 R8 R10 store ds elem", 32'h3FFF_FFFE, 1'b1);
        dst_step = 7'd127; dst_sub = 2'd3; subvl = 2'd3; disp_fld = 16'h2001;
        step_and_check("R5 R8 store max pos");
        remap_en = 1'b0;
    endtask

    task automatic t_no_access();
        kind = 2'd0; mode = 2'd2; form = 1'b0; disp_fld = 16'h7FFF; src_step = 7'd4;
        @(negedge clk);
        check("R6 elem none", 32'h0, 1'b1);
        kind = 2'd3; mode = 2'd1; disp_fld = 16'h8000;
        @(negedge clk);
        check("R6 R1 unit none", 32'hFFFF_8000, 1'b1);
    endtask

    task automatic t_other_modes();
        kind = 2'd1; src_step = 7'd6; disp_fld = 16'h1234; form = 1'b0;
        mode = 2'd0;
        @(negedge clk);
        check("R9 mode0", 32'h0, 1'b0);
        mode = 2'd3; form = 1'b1;
        @(negedge clk);
        check("R9 mode3", 32'h0, 1'b0);
    endtask

    task automatic t_lengths();
        kind = 2'd1; mode = 2'd1; form = 1'b0; disp_fld = 16'h0000;
        src_step = 7'd3; src_sub = 2'd0; subvl = 2'd0;
        for (int i = 0; i < 5; i++) begin
            len = (i == 4) ? 4'd3 : 4'(1 << i);
            @(negedge clk);
            check("R11 size", (i == 4) ? 32'd3 : 32'(3 << i), 1'b1);
        end
        form = 1'b1; disp_fld = 16'h2000; len = 4'd8; src_step = 7'd1;
        step_and_check("R2 R10 R7 ds negative unit");
    endtask

    task automatic t_elem_wrap();
        kind = 2'd1; mode = 2'd2; form = 1'b0; disp_fld = 16'h8000;
        src_step = 7'd127; subvl = 2'd3; src_sub = 2'd3;
        @(negedge clk);
        check("R8 elem negative", 32'hFF00_8000, 1'b1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_load_unit_d();
        t_load_remap();
        t_store_ds_elem();
        t_no_access();
        t_other_modes();
        t_lengths();
        t_elem_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule